// File: doc/BRIEF.md
# Multiply-Accumulate Macro Instruction Unit

This unit executes one added macro instruction on an 8-bit accumulator-style processor core. The instruction is four bytes long. The first byte is the opcode `8'b00000011`. The second byte picks a source register. The third and fourth bytes give a 16-bit memory address. The unit computes R0 = R0 + R[n] * mem[address] and writes the result back to R0. The core raises `start` in the cycle in which it recognises the opcode, and it drives `pc_in` with the address of that opcode byte. From then on the unit owns the core's byte-wide memory read port and its register-file port.

After `start`, the unit reads the three remaining instruction bytes in turn, then the operand byte. It forms the product with an 8-step shift-and-add multiplier and writes the sum to R0. It asserts `done` for one cycle, and in that same cycle presents on `pc_out` the address just past the instruction. Every instruction takes the same number of cycles, whatever its register index or data values. Fetching other instructions, interrupts and the rest of the core lie outside the block.

Top module: `mac_macro_unit`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy`, `done`, `rf_we` and `mem_rd` are all 0, provided `start` is low.
- R2: When the unit is idle and `start` is high, the unit drives `mem_rd`=1 and `mem_addr`=`pc_in`+1 in that same cycle. `busy` goes high in the next cycle.
- R3: Memory reads return their data one cycle after the address is presented. In cycles 2 and 3 (the start cycle is cycle 1), the unit reads `pc_in`+2 and `pc_in`+3. In cycle 4 it reads the operand at address {byte at `pc_in`+3, byte at `pc_in`+2}, low byte first. No other cycle asserts `mem_rd`.
- R4: In cycle 13, `rf_we`=1, `rf_waddr`=0 and `rf_wdata` = (R0 + R[n]*operand) mod 256. Here n is bits [2:0] of the byte at `pc_in`+1, and bits [7:3] of that byte are ignored. `rf_we` is 0 in every other cycle.
- R5: When n is 0, the original R0 is used as the multiplicand, giving (R0 + R0*operand) mod 256.
- R6: `done` is high for exactly one cycle, cycle 13, for every choice of register and data. In the following cycle the unit is idle (`busy`=0) and can accept a new `start`.
- R7: In the `done` cycle, `pc_out` equals `pc_in`+4 modulo 2^16.
- R8: A `start` that arrives while `busy` is high is ignored. It changes neither the result, the timing, the memory reads nor `pc_out`.
- R9: The register file is read combinationally. In cycle 3, `rf_raddr` is n. In cycle 4, `rf_raddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opcode recognised by the core; accepted only when idle |
| pc_in | input | 16 | Address of the opcode byte, sampled with `start` |
| busy | output | 1 | Instruction in progress (cycles 2 to 13) |
| done | output | 1 | One-cycle completion strobe, cycle 13 |
| pc_out | output | 16 | Address past the instruction, valid with `done` |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 8 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index (always R0) |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The hardest cases to reach from the ports are a second `start` that lands in the middle of an instruction, and a new instruction that starts in the very first idle cycle after `done`. In the second case the new instruction must see the R0 value that was just written. The stimulus places one stray `start` pulse, carrying a junk `pc_in`, at a chosen or random cycle from 2 through 13. It also issues an instruction right after a completed one without reloading the registers. Separate directed cases cover register index 0, a register byte with its upper bits set, results that overflow 8 bits, and a `pc_in` near the top of the address space.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_RN,
    ST_GET_LO,
    ST_GET_HI,
    ST_MUL_FIRST,
    ST_MUL_RUN,
    ST_WRITE
  } mac_state_e;
endpackage

// File: rtl/mac_shift_mult.sv
module mac_shift_mult #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          first,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] mcand,
  output logic [DW-1:0] prod,
  output logic          last
);
  localparam logic [CW-1:0] LAST_IT = CW'(DW - 1);

  logic          running_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] mlt_q, msh_q, prod_q;

  // The first iteration consumes the operand straight from the memory port.
  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else if (first) begin
      running_q <= 1'b1;
      cnt_q     <= CW'(1);
    end else if (running_q) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == LAST_IT) running_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (first) begin
      prod_q <= opnd[0] ? mcand : '0;
      mlt_q  <= opnd >> 1;
      msh_q  <= mcand << 1;
    end else if (running_q) begin
      prod_q <= prod_q + (mlt_q[0] ? msh_q : '0);
      mlt_q  <= mlt_q >> 1;
      msh_q  <= msh_q << 1;
    end
  end

  assign prod = prod_q;
  assign last = running_q && (cnt_q == LAST_IT);

  // R6
  mult_restart_chk: assert property (@(posedge clk) disable iff (rst)
    first |-> !running_q);
endmodule

// File: rtl/mac_seq.sv
module mac_seq
  import mac_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] rf_rdata,
  input  logic          mult_last,
  input  logic [DW-1:0] prod,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [RW-1:0] rf_raddr,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mult_first,
  output logic [DW-1:0] mcand
);
  localparam int LATENCY = DW + 5;
  localparam int LW      = $clog2(LATENCY + 1);

  mac_state_e    state_q, state_d;
  logic [AW-1:0] pc_q;
  logic [RW-1:0] rn_q;
  logic [DW-1:0] lo_q, mcand_q, r0_q;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start) state_d = ST_GET_RN;
      ST_GET_RN:    state_d = ST_GET_LO;
      ST_GET_LO:    state_d = ST_GET_HI;
      ST_GET_HI:    state_d = ST_MUL_FIRST;
      ST_MUL_FIRST: state_d = ST_MUL_RUN;
      ST_MUL_RUN:   if (mult_last) state_d = ST_WRITE;
      ST_WRITE:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // Instruction-byte capture and program counter advance.
  always_ff @(posedge clk) begin
    if (accept) pc_q <= pc_in + AW'(2);
    case (state_q)
      ST_GET_RN: begin
        rn_q <= mem_rdata[RW-1:0];
        pc_q <= pc_q + AW'(1);
      end
      ST_GET_LO: begin
        lo_q    <= mem_rdata;
        mcand_q <= rf_rdata;
        pc_q    <= pc_q + AW'(1);
      end
      ST_GET_HI: r0_q <= rf_rdata;
      default: ;
    endcase
  end

  // Memory and register-file read requests.
  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = pc_q;
    rf_raddr = '0;
    case (state_q)
      ST_IDLE: begin
        mem_rd   = start;
        mem_addr = pc_in + AW'(1);
      end
      ST_GET_RN: mem_rd = 1'b1;
      ST_GET_LO: begin
        mem_rd   = 1'b1;
        rf_raddr = rn_q;
      end
      ST_GET_HI: begin
        mem_rd   = 1'b1;
        mem_addr = AW'({mem_rdata, lo_q});
      end
      default: ;
    endcase
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_WRITE);
  assign rf_we      = done;
  assign rf_waddr   = '0;
  assign rf_wdata   = r0_q + prod;
  assign pc_out     = pc_q;
  assign mult_first = (state_q == ST_MUL_FIRST);
  assign mcand      = mcand_q;

  // Cycle counter used only by the latency check below.
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk) begin
    if (rst)                    lat_q <= '0;
    else if (accept)            lat_q <= LW'(2);
    else if (state_q != ST_IDLE) lat_q <= lat_q + LW'(1);
    else                        lat_q <= '0;
  end

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == LW'(LATENCY)));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/mac_macro_unit.sv
module mac_macro_unit #(
  parameter int DATA_W  = 8,
  parameter int REG_CNT = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int RIDX_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] pc_out,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic              mult_first, mult_last;
  logic [DATA_W-1:0] mcand, prod;

  mac_seq #(.DW(DATA_W), .AW(ADDR_W), .RW(RIDX_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pc_in      (pc_in),
    .mem_rdata  (mem_rdata),
    .rf_rdata   (rf_rdata),
    .mult_last  (mult_last),
    .prod       (prod),
    .busy       (busy),
    .done       (done),
    .pc_out     (pc_out),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .rf_raddr   (rf_raddr),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .mult_first (mult_first),
    .mcand      (mcand)
  );

  mac_shift_mult #(.DW(DATA_W)) u_mult (
    .clk   (clk),
    .rst   (rst),
    .first (mult_first),
    .opnd  (mem_rdata),
    .mcand (mcand),
    .prod  (prod),
    .last  (mult_last)
  );
endmodule

// File: tb/tb_mac_macro_unit.sv
module tb_mac_macro_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic        busy, done, mem_rd, rf_we;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [7:0]  rf_rdata, rf_wdata;

  always #10 clk = ~clk;

  mac_macro_unit dut (
    .clk(clk), .rst(rst), .start(start), .pc_in(pc_in),
    .busy(busy), .done(done), .pc_out(pc_out),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: sparse writes over a computed background pattern.
  logic [7:0] memmap [int];
  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    if (memmap.exists(int'(a))) return memmap[int'(a)];
    return 8'(a * 7) ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= rd_mem(mem_addr);

  // Register file model.
  logic [7:0] rf [8];
  logic [7:0] rf_init [8];
  logic       load_rf = 1'b0;
  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    else if (load_rf) for (int i = 0; i < 8; i++) rf[i] <= rf_init[i];
  end

  // Cycle-level reference model.
  int         ref_cyc = 0;
  logic [15:0] e_pc, e_addr;
  logic [2:0]  e_rn;
  logic [7:0]  e_w;
  logic [15:0] t_pc, t_addr;
  logic [7:0]  t_b, t_m;
  always @(posedge clk) begin
    if (rst) ref_cyc <= 0;
    else if (ref_cyc == 0) begin
      if (start) begin
        t_pc   = pc_in;
        t_b    = rd_mem(t_pc + 16'd1);
        t_addr = {rd_mem(t_pc + 16'd3), rd_mem(t_pc + 16'd2)};
        t_m    = rd_mem(t_addr);
        e_pc   <= t_pc;
        e_rn   <= t_b[2:0];
        e_addr <= t_addr;
        e_w    <= rf[0] + rf[t_b[2:0]] * t_m;
        ref_cyc <= 2;
      end
    end else if (ref_cyc == 13) ref_cyc <= 0;
    else ref_cyc <= ref_cyc + 1;
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy", busy, ref_cyc != 0);
      chk("R6 done", done, ref_cyc == 13);
      chk("R3 mem_rd", mem_rd, (ref_cyc == 0 && start) || (ref_cyc >= 2 && ref_cyc <= 4));
      chk("R4 rf_we", rf_we, ref_cyc == 13);
      if (ref_cyc == 0 && start) chk("R2 mem_addr", mem_addr, 16'(pc_in + 16'd1));
      if (ref_cyc == 2) chk("R3 mem_addr", mem_addr, 16'(e_pc + 16'd2));
      if (ref_cyc == 3) begin
        chk("R3 mem_addr", mem_addr, 16'(e_pc + 16'd3));
        chk("R9 rf_raddr", rf_raddr, e_rn);
      end
      if (ref_cyc == 4) begin
        chk("R3 mem_addr", mem_addr, e_addr);
        chk("R9 rf_raddr", rf_raddr, 0);
      end
      if (ref_cyc == 13) begin
        chk("R4 rf_waddr", rf_waddr, 0);
        chk(e_rn == 0 ? "R5 rf_wdata" : "R4 rf_wdata", rf_wdata, e_w);
        chk("R7 pc_out", pc_out, 16'(e_pc + 16'd4));
      end
    end
  end

  // One instruction; inj in 2..13 places a stray start in that cycle.
  task automatic run_op(input logic [15:0] pc, input logic [7:0] rnb,
                        input logic [15:0] a, input logic [7:0] m,
                        input logic [7:0] r0v, input logic [7:0] rnv,
                        input int inj, input bit keep_rf);
    logic [7:0] exp, r0c, rnc;
    logic [2:0] rn;
    memmap[int'(pc)]         = 8'b0000_0011;
    memmap[int'(pc + 16'd1)] = rnb;
    memmap[int'(pc + 16'd2)] = a[7:0];
    memmap[int'(pc + 16'd3)] = a[15:8];
    memmap[int'(a)]          = m;
    rn = rd_mem(pc + 16'd1);
    if (!keep_rf) begin
      for (int i = 0; i < 8; i++) rf_init[i] = 8'($urandom);
      rf_init[0] = r0v;
      if (rn != 0) rf_init[rn] = rnv;
      load_rf = 1'b1;
      @(posedge clk); #1 load_rf = 1'b0;
    end
    r0c = rf[0];
    rnc = rf[rn];
    exp = r0c + rnc * rd_mem({rd_mem(pc + 16'd3), rd_mem(pc + 16'd2)});
    start = 1'b1; pc_in = pc;
    @(posedge clk); #1 start = 1'b0; pc_in = ~pc;
    for (int c = 2; c <= 13; c++) begin
      if (c == inj) begin start = 1'b1; pc_in = 16'($urandom); end
      @(posedge clk); #1 start = 1'b0;
    end
    if (inj != 0) chk("R8 r0 after stray start", rf[0], exp);
    else if (rn == 0) chk("R5 r0 final", rf[0], exp);
    else chk("R4 r0 final", rf[0], exp);
    chk("R6 idle after done", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", busy, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 rf_we in reset", rf_we, 0);
    chk("R1 mem_rd in reset", mem_rd, 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);

    run_op(16'h0100, 8'h03, 16'h2345, 8'd5,   8'd10,  8'd7,   0, 0);
    run_op(16'h0200, 8'h00, 16'h3000, 8'd3,   8'd9,   8'd0,   0, 0); // R5
    run_op(16'h0300, 8'hFD, 16'h4001, 8'd200, 8'd250, 8'd255, 0, 0); // R4 upper bits, overflow
    run_op(16'hFFFE, 8'h07, 16'h8000, 8'd255, 8'd255, 8'd255, 0, 0); // R7 wrap
    run_op(16'h0400, 8'h02, 16'h5000, 8'd17,  8'd1,   8'd33,  6, 0); // R8
    run_op(16'h0500, 8'h01, 16'h5100, 8'd9,   8'd2,   8'd4,   13, 0); // R8 in done cycle
    run_op(16'h0600, 8'h01, 16'h5200, 8'd3,   8'd0,   8'd0,   0, 1); // back-to-back, R6
    for (int k = 0; k < 40; k++) begin
      logic [15:0] pc, a;
      int inj;
      pc  = 16'($urandom);
      a   = 16'($urandom);
      if (a - pc < 16'd4) a = a + 16'd8;
      inj = ($urandom % 3 == 0) ? 2 + int'($urandom % 12) : 0;
      run_op(pc, 8'($urandom), a, 8'($urandom), 8'($urandom), 8'($urandom),
             inj, ($urandom % 4) == 0);
    end
    repeat (3) @(posedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule